// File: doc/BRIEF.md
# Serial PLL Program Word Receiver

This block is the receiving end of a two-wire serial link, one wire a slow clock and one a data wire, that programs a frequency synthesizer. Both wires come from another clock domain, so each passes through a two-flop synchronizer. The block then finds the edges of the link clock by comparing each synchronized sample with the one before it. While idle the receiver is locked. It ignores traffic until it sees a run of link-clock rising edges with the data wire high, closed by a rising edge with the data wire low.

After unlocking it expects a start bit and then 24 data bits, least significant bit first. Each data bit uses a split encoding: the value on the rising edge is the bit, and the value on the falling edge just before it must be the bit's complement. A stop bit closes the frame. The top three bits of the word pick one of the program registers, and the low 21 bits are the payload. The payload holds an index field at bit 17 (4 bits), N at bit 10 (7 bits), P at bit 7 (3 bits) and D at bit 0 (7 bits). A good frame writes the payload into the chosen register and pulses `load_valid_o`. A malformed frame raises `err_o`, discards the partial word and locks the receiver again.

Top module: `pll_word_rx`

## Requirements
- R1: The receiver leaves the locked state only when a link-clock rising edge with data low follows at least UNLOCK_N (default 5) rising edges with data high. With fewer, it stays locked, nothing is written and no error is raised.
- R2: Both link wires are sampled through SYNC_N (default 2) flip-flops. A level held for a single system clock is still decoded correctly.
- R3: After unlock, the next rising edge is the start bit and must see data low. If data is high there, `err_o` pulses and the receiver locks again.
- R4: The 24 data bits are the data values on successive rising edges and are assembled least significant bit first into word[23:0].
- R5: If a data bit's rising-edge value equals the value seen on the falling edge just before it, `err_o` pulses for one cycle, the partial word is discarded, no register changes and the receiver locks again.
- R6: After the 24th bit, the next rising edge is the stop bit and must see data high. If data is low, `err_o` pulses and nothing is written.
- R7: A good frame with select word[23:21] below NREG (default 4) writes word[20:0] into register select, which appears at `regs_o[select*21 +: 21]`. The other registers are left unchanged, and `load_valid_o` is high for exactly one cycle.
- R8: A good frame whose select is NREG or more writes nothing, gives no `load_valid_o` pulse and no `err_o` pulse.
- R9: After reset, every register reads 0, both pulse outputs are low and the receiver is locked.
- R10: After every finished or rejected frame the receiver is locked again, so each new frame needs its own unlock preamble.
- R11: `load_valid_o` and `err_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_clk_i | input | 1 | Serial link clock wire (asynchronous) |
| link_dat_i | input | 1 | Serial link data wire (asynchronous) |
| regs_o | output | NREG*21 | Program registers, register k at bits [k*21 +: 21] |
| load_valid_o | output | 1 | One-cycle pulse when a register is written |
| err_o | output | 1 | One-cycle pulse when a frame is rejected |

## Verification
The assertions assume that the link clock and data wire never change in the same system cycle, so that every synchronized rising edge sees a settled data level. The bench keeps to this by changing one wire per step and holding each step for at least one system clock. It takes the hold down to a single clock to test the edge detector at its limit. When a frame is corrupted on purpose, the bench stops driving it at the faulty bit. The next frame then begins from a locked receiver, and stray data bits cannot unlock it.

// File: rtl/pllrx_pkg.sv
package pllrx_pkg;
  parameter int WORD_W = 24;
  parameter int SEL_W  = 3;
  localparam int PAY_W = WORD_W - SEL_W;

  typedef enum logic [1:0] {
    RX_LOCKED = 2'd0,
    RX_START  = 2'd1,
    RX_DATA   = 2'd2,
    RX_STOP   = 2'd3
  } rx_state_e;

  function automatic logic [SEL_W-1:0] word_sel(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: SEL_W];
  endfunction

  function automatic logic [PAY_W-1:0] word_payload(input logic [WORD_W-1:0] w);
    return w[PAY_W-1:0];
  endfunction

  // a data bit is valid when its rising-edge value is the inverse of the falling-edge value
  function automatic logic bit_pair_ok(input logic rise_val, input logic fall_val);
    return rise_val ^ fall_val;
  endfunction
endpackage

// File: rtl/pllrx_sync.sv
module pllrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[STAGES-2:0], d};
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pllrx_framer.sv
module pllrx_framer
  import pllrx_pkg::*;
#(
  parameter int UNLOCK_N = 5,
  localparam int HW = $clog2(UNLOCK_N + 1),
  localparam int BW = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              fall,
  input  logic              dat,
  output rx_state_e         state,
  output logic [HW-1:0]     hi_cnt,
  output logic [BW-1:0]     bit_cnt,
  output logic [WORD_W-1:0] word,
  output logic              word_done,
  output logic              frame_err
);
  localparam logic [HW-1:0] UNLOCK_L = HW'(UNLOCK_N);
  localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);

  logic fall_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_LOCKED;
      hi_cnt    <= '0;
      bit_cnt   <= '0;
      word      <= '0;
      fall_val  <= 1'b0;
      word_done <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      word_done <= 1'b0;
      frame_err <= 1'b0;
      if (fall) fall_val <= dat;
      if (rise) begin
        unique case (state)
          RX_LOCKED: begin
            if (dat) begin
              if (hi_cnt != UNLOCK_L) hi_cnt <= hi_cnt + 1'b1;
            end else begin
              if (hi_cnt >= UNLOCK_L) state <= RX_START;
              hi_cnt <= '0;
            end
          end
          RX_START: begin
            if (!dat) begin
              state   <= RX_DATA;
              bit_cnt <= '0;
            end else begin
              state     <= RX_LOCKED;
              frame_err <= 1'b1;
            end
          end
          RX_DATA: begin
            if (bit_pair_ok(dat, fall_val)) begin
              word    <= {dat, word[WORD_W-1:1]};
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == LAST_BIT) state <= RX_STOP;
            end else begin
              state     <= RX_LOCKED;
              word      <= '0;
              frame_err <= 1'b1;
            end
          end
          RX_STOP: begin
            state <= RX_LOCKED;
            if (dat) word_done <= 1'b1;
            else begin
              word      <= '0;
              frame_err <= 1'b1;
            end
          end
          default: state <= RX_LOCKED;
        endcase
      end
    end
  end
endmodule

// File: rtl/pllrx_regbank.sv
module pllrx_regbank
  import pllrx_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  word_done,
  input  logic [WORD_W-1:0]     word,
  output logic [NREG*PAY_W-1:0] regs,
  output logic                  load_valid
);
  localparam logic [SEL_W:0] NREG_L = (SEL_W+1)'(NREG);

  logic [SEL_W-1:0] sel;
  logic             sel_ok;

  assign sel    = word_sel(word);
  assign sel_ok = {1'b0, sel} < NREG_L;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_valid <= 1'b0;
    else        load_valid <= word_done && sel_ok;
  end

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[k*PAY_W +: PAY_W] <= '0;
      else if (word_done && sel_ok && ({1'b0, sel} == (SEL_W+1)'(k)))
        regs[k*PAY_W +: PAY_W] <= word_payload(word);
    end
  end
endmodule

// File: rtl/pll_word_rx.sv
module pll_word_rx
  import pllrx_pkg::*;
#(
  parameter int NREG     = 4,
  parameter int UNLOCK_N = 5,
  parameter int SYNC_N   = 2,
  localparam int HW = $clog2(UNLOCK_N + 1),
  localparam int BW = $clog2(WORD_W)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  link_clk_i,
  input  logic                  link_dat_i,
  output logic [NREG*PAY_W-1:0] regs_o,
  output logic                  load_valid_o,
  output logic                  err_o
);
  logic [1:0]  pin_raw, pin_s;
  logic        clk_prev;
  logic        clk_rise, clk_fall, dat_s;
  rx_state_e   rx_state;
  logic [HW-1:0]     hi_cnt;
  logic [BW-1:0]     bit_cnt;
  logic [WORD_W-1:0] word;
  logic              word_done, frame_err;

  assign pin_raw = {link_dat_i, link_clk_i};

  for (genvar p = 0; p < 2; p++) begin : g_sync
    pllrx_sync #(.STAGES(SYNC_N)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_raw[p]), .q(pin_s[p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev <= 1'b0;
    else        clk_prev <= pin_s[0];
  end

  assign clk_rise = pin_s[0] & ~clk_prev;
  assign clk_fall = ~pin_s[0] & clk_prev;
  assign dat_s    = pin_s[1];

  pllrx_framer #(.UNLOCK_N(UNLOCK_N)) u_framer (
    .clk(clk), .rst_n(rst_n), .rise(clk_rise), .fall(clk_fall), .dat(dat_s),
    .state(rx_state), .hi_cnt(hi_cnt), .bit_cnt(bit_cnt), .word(word),
    .word_done(word_done), .frame_err(frame_err)
  );

  pllrx_regbank #(.NREG(NREG)) u_regbank (
    .clk(clk), .rst_n(rst_n), .word_done(word_done), .word(word),
    .regs(regs_o), .load_valid(load_valid_o)
  );

  assign err_o = frame_err;
endmodule

// File: rtl/pllrx_checker.sv
module pllrx_checker
  import pllrx_pkg::*;
#(
  parameter int NREG     = 4,
  parameter int UNLOCK_N = 5,
  localparam int HW = $clog2(UNLOCK_N + 1),
  localparam int BW = $clog2(WORD_W)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rise,
  input logic                  dat,
  input rx_state_e             state,
  input logic [HW-1:0]         hi_cnt,
  input logic [BW-1:0]         bit_cnt,
  input logic                  word_done,
  input logic                  frame_err,
  input logic                  load_valid,
  input logic [NREG*PAY_W-1:0] regs
);
  localparam logic [HW-1:0] UNLOCK_L = HW'(UNLOCK_N);
  localparam logic [BW-1:0] WORD_L   = BW'(WORD_W - 1);

  assert_unlock_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_START && $past(state) != RX_START) |->
      ($past(state) == RX_LOCKED && $past(rise) && !$past(dat) && $past(hi_cnt) >= UNLOCK_L));

  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_DATA && $past(state) == RX_START) |-> !$past(dat));

  assert_bit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_DATA) |-> (bit_cnt <= WORD_L));

  assert_err_relock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> (state == RX_LOCKED));

  assert_stop_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> ($past(state) == RX_STOP && $past(rise) && $past(dat)));

  assert_regs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_valid |-> $stable(regs));

  assert_load_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |-> $past(word_done));

  assert_done_relock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> (state == RX_LOCKED));

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_valid, frame_err}));
endmodule

bind pll_word_rx pllrx_checker #(.NREG(NREG), .UNLOCK_N(UNLOCK_N)) u_pllrx_checker (
  .clk(clk), .rst_n(rst_n), .rise(clk_rise), .dat(dat_s), .state(rx_state),
  .hi_cnt(hi_cnt), .bit_cnt(bit_cnt), .word_done(word_done), .frame_err(frame_err),
  .load_valid(load_valid_o), .regs(regs_o)
);

// File: tb/test_pll_word_rx.sv
`timescale 1ns/1ps
module test_pll_word_rx;
  localparam int NREG = 4;
  localparam int PW   = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_clk = 1'b0, link_dat = 1'b0;
  logic [NREG*PW-1:0] regs;
  logic lv, err;

  int tests = 0, fails = 0;
  int lv_cnt = 0, err_cnt = 0;
  int hold = 3;
  logic [PW-1:0] exp_reg [NREG];

  always #10 clk = ~clk;

  pll_word_rx #(.NREG(NREG)) i_pll_word_rx (
    .clk(clk), .rst_n(rst_n), .link_clk_i(link_clk), .link_dat_i(link_dat),
    .regs_o(regs), .load_valid_o(lv), .err_o(err)
  );

  always @(negedge clk) begin
    if (lv)  lv_cnt++;
    if (err) err_cnt++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pins(input logic c, input logic d);
    link_clk = c;
    link_dat = d;
    repeat (hold) @(negedge clk);
  endtask

  function automatic logic [PW-1:0] pack_fields(input int idx, input int n, input int p, input int d);
    return PW'((idx % 16) * 131072 + (n % 128) * 1024 + (p % 8) * 128 + (d % 128));
  endfunction

  // bad_bit: index of the data bit sent with a matching (wrong) falling-edge value, -1 for none
  task automatic send_frame(input logic [23:0] w, input int npre, input int bad_bit,
                            input bit bad_start, input bit bad_stop);
    pins(0, 0); pins(0, 1);
    repeat (npre) begin pins(1, 1); pins(0, 1); end
    pins(0, 0); pins(1, 0);
    pins(0, 0); pins(1, bad_start);
    if (bad_start) return;
    for (int i = 0; i < 24; i++) begin
      logic b, fv;
      b  = w[i];
      fv = (i == bad_bit) ? b : ~b;
      pins(1, fv); pins(0, fv); pins(0, b); pins(1, b);
      if (i == bad_bit) return;
    end
    pins(1, 1); pins(0, 1); pins(1, !bad_stop);
  endtask

  task automatic check_regs(input string req);
    for (int k = 0; k < NREG; k++)
      chk(regs[k*PW +: PW] == exp_reg[k], req, regs[k*PW +: PW], exp_reg[k]);
  endtask

  // full frame plus expected outcome
  task automatic run(input logic [2:0] sel, input logic [PW-1:0] pay, input int npre,
                     input int bad_bit, input bit bad_start, input bit bad_stop,
                     input bit exp_load, input bit exp_err, input string req);
    int lv0, er0;
    lv0 = lv_cnt; er0 = err_cnt;
    send_frame({sel, pay}, npre, bad_bit, bad_start, bad_stop);
    repeat (8) @(negedge clk);
    if (exp_load) exp_reg[sel] = pay;
    chk(lv_cnt - lv0 == int'(exp_load), {req, " load_valid pulses"}, lv_cnt - lv0, int'(exp_load));
    chk(err_cnt - er0 == int'(exp_err), {req, " err pulses"}, err_cnt - er0, int'(exp_err));
    check_regs({req, " regs"});
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < NREG; k++) exp_reg[k] = '0;
    repeat (4) @(negedge clk);
    // R9: reset state
    check_regs("R9");
    chk(lv == 1'b0, "R9 load_valid", lv, 0);
    chk(err == 1'b0, "R9 err", err, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4 R7 R8: sweep every select with several payloads
    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < 3; k++) begin
        logic [PW-1:0] pay;
        pay = (k == 2) ? pack_fields(s + 3, 17 * s + 5, s, 99 - s)
                       : PW'((s * 37 + k * 1013) * 2749 + k);
        run(3'(s), pay, 5, -1, 0, 0, s < NREG, 0, s < NREG ? "R7" : "R8");
      end
    end
    // R4: extreme payloads
    run(3'd2, 21'h1FFFFF, 5, -1, 0, 0, 1, 0, "R4");
    run(3'd1, 21'h000000, 5, -1, 0, 0, 1, 0, "R4");
    run(3'd3, 21'h100001, 6, -1, 0, 0, 1, 0, "R4");

    // R1: longer preamble accepted, shorter one ignored
    run(3'd0, 21'h0ABCDE, 9, -1, 0, 0, 1, 0, "R1");
    run(3'd1, 21'h0AAAAA, 4, -1, 0, 0, 0, 0, "R1");
    // R10: after a good frame, bits without preamble are not accepted
    run(3'd1, 21'h0AAAAA, 0, -1, 0, 0, 0, 0, "R10");

    // R3: bad start bit
    run(3'd2, 21'h012345, 5, -1, 1, 0, 0, 1, "R3");
    // R5: complement mismatch at first, middle and last bit
    run(3'd0, 21'h155555, 5, 0, 0, 0, 0, 1, "R5");
    run(3'd1, 21'h0F0F0F, 5, 11, 0, 0, 0, 1, "R5");
    run(3'd3, 21'h1E1E1E, 5, 23, 0, 0, 0, 1, "R5");
    // R6: bad stop bit
    run(3'd2, 21'h07654F, 5, -1, 0, 1, 0, 1, "R6");
    // R10: recovery after rejected frames
    run(3'd2, 21'h13579B, 5, -1, 0, 0, 1, 0, "R10");

    // R2: single-clock levels still decode
    hold = 1;
    run(3'd0, 21'h1A2B3C, 5, -1, 0, 0, 1, 0, "R2");
    run(3'd3, pack_fields(9, 100, 5, 42), 5, -1, 0, 0, 1, 0, "R2");
    hold = 3;

    // R11: no cycle had both pulses (counted via a dedicated monitor below)
    chk(both_seen == 0, "R11 simultaneous pulses", both_seen, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  int both_seen = 0;
  always @(negedge clk) if (lv && err) both_seen++;
endmodule